// File: doc/BRIEF.md
# I2C Multi-Address Slave Matcher

This block decides whether the first byte a bus target receives after a START (or a repeated START) is addressed to it. It checks that byte against a bank of programmable 7-bit slave addresses. Each slot has its own mask, which turns chosen address bits into don't-care bits. The byte is also checked against the broadcast General Call value 0x00. An upstream bus engine pulses `start_seen` when a START condition occurs and `byte_valid` when a byte is complete. This block does not sample the bus and does not drive ACK.

On a match the block gives a one-cycle `match_pulse` and the index of the winning slot. It also gives a general-call flag and the read/write bit of the byte. It keeps a latched copy of the whole received byte, so software can tell which concrete address caused a masked match. A sticky interrupt request is raised and stays high until software pulses `irq_clear`.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After synchronous reset, `match_pulse`, `gc_hit`, `rw_bit`, `irq`, `match_slot` and `rx_addr` are all zero.
- R2: Slot n holds its address in bits 7:1 of byte n of `slot_addr` and its mask in the 7 bits n of `slot_mask`. Mask bit k set (k = 0..6, matching received bit k+1) makes that bit don't-care. A non-zero byte matches slot n when every unmasked received bit 7:1 equals the slot's bit.
- R3: When several slots match, `match_slot` reports the lowest-numbered matching slot.
- R4: Received bit 0 (R/W) takes no part in the address comparison. On a match it is output on `rw_bit`.
- R5: The byte 0x00 is treated only as a General Call. It matches when at least one slot has bit 0 of its `slot_addr` byte set. It then gives `gc_hit`=1 and `match_slot` = the lowest slot with that enable set. With no enable set, 0x00 does not match.
- R6: Only the first `byte_valid` after a `start_seen` pulse is compared. Later bytes give no match, and `irq` and `rx_addr` stay as they were until the next `start_seen`.
- R7: `match_pulse` is high for exactly the one cycle after the clock edge that samples the matching `byte_valid`. `match_slot`, `gc_hit` and `rw_bit` are valid in that same cycle.
- R8: `irq` is set together with `match_pulse` and stays high until `irq_clear` is sampled high. If a new match and `irq_clear` occur at the same edge, `irq` stays set.
- R9: `rx_addr` is loaded with the received byte on each match and holds its value otherwise.
- R10: A compared byte that matches no slot gives no `match_pulse` and leaves `irq` and `rx_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_seen | input | 1 | Pulse: START or repeated START detected |
| byte_valid | input | 1 | Pulse: `rx_byte` holds a complete byte |
| rx_byte | input | 8 | Received byte, MSB first on the bus |
| slot_addr | input | 8*NUM_SLOTS | Per slot: address in bits 7:1, General Call enable in bit 0 |
| slot_mask | input | 7*NUM_SLOTS | Per slot: don't-care bits for address bits 7:1 |
| irq_clear | input | 1 | Pulse: clears the interrupt request |
| match_pulse | output | 1 | One-cycle match indication |
| match_slot | output | IDX_W | Index of the winning slot |
| gc_hit | output | 1 | Match was a General Call |
| rw_bit | output | 1 | R/W bit of the matched byte |
| rx_addr | output | 8 | Latched received address byte |
| irq | output | 1 | Sticky interrupt request |

## Verification
A wrong armed state shows up on the first data byte that follows an address. A spurious `match_pulse` and an overwritten `rx_addr` appear one cycle after that strobe. A missing re-arm instead suppresses the pulse for a correct address after a repeated START. Faults in the compare or priority logic show at `match_slot` and `gc_hit` in the cycle after the strobe. A faulty interrupt register shows as `irq` dropping without `irq_clear`, or surviving one.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
    localparam int ADDR_W    = 7;
    localparam int BYTE_W    = ADDR_W + 1;
    localparam int DEF_SLOTS = 4;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Event captured on a successful comparison
    typedef struct packed {
        logic  gc;
        byte_t addr;
    } match_evt_t;

    // Masked 7-bit compare: set mask bits exclude that position
    function automatic logic masked_equal(addr_t rx_a, addr_t slot_a, addr_t dont_care);
        return ((rx_a ^ slot_a) & ~dont_care) == '0;
    endfunction
endpackage

// File: rtl/i2c_slot_compare.sv
module i2c_slot_compare
    import i2c_addr_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS
) (
    input  byte_t                       rx_byte,
    input  logic [NUM_SLOTS*BYTE_W-1:0] slot_addr,
    input  logic [NUM_SLOTS*ADDR_W-1:0] slot_mask,
    output logic [NUM_SLOTS-1:0]        addr_hit,
    output logic [NUM_SLOTS-1:0]        gc_enable
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        byte_t slot_byte;
        addr_t slot_dc;
        assign slot_byte   = slot_addr[s*BYTE_W +: BYTE_W];
        assign slot_dc     = slot_mask[s*ADDR_W +: ADDR_W];
        assign addr_hit[s] = masked_equal(rx_byte[BYTE_W-1:1], slot_byte[BYTE_W-1:1], slot_dc);
        assign gc_enable[s] = slot_byte[0];
    end
endmodule

// File: rtl/i2c_prio_pick.sv
module i2c_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/i2c_match_event.sv
module i2c_match_event
    import i2c_addr_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  match_evt_t       evt,
    input  logic [IDX_W-1:0] idx,
    input  logic             irq_clear,
    output logic             match_pulse,
    output logic [IDX_W-1:0] match_slot,
    output logic             gc_hit,
    output logic             rw_bit,
    output byte_t            rx_addr,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            match_pulse <= 1'b0;
            match_slot  <= '0;
            gc_hit      <= 1'b0;
            rw_bit      <= 1'b0;
            rx_addr     <= '0;
            irq         <= 1'b0;
        end else begin
            match_pulse <= fire;
            if (fire) begin
                match_slot <= idx;
                gc_hit     <= evt.gc;
                rw_bit     <= evt.addr[0];
                rx_addr    <= evt.addr;
                irq        <= 1'b1;
            end else begin
                gc_hit <= 1'b0;
                if (irq_clear) irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
    import i2c_addr_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_seen,
    input  logic                        byte_valid,
    input  logic [BYTE_W-1:0]           rx_byte,
    input  logic [NUM_SLOTS*BYTE_W-1:0] slot_addr,
    input  logic [NUM_SLOTS*ADDR_W-1:0] slot_mask,
    input  logic                        irq_clear,
    output logic                        match_pulse,
    output logic [IDX_W-1:0]            match_slot,
    output logic                        gc_hit,
    output logic                        rw_bit,
    output logic [BYTE_W-1:0]           rx_addr,
    output logic                        irq
);
    logic [NUM_SLOTS-1:0] addr_hit, gc_enable, sel_req;
    logic                 any_hit, armed, is_gc, fire;
    logic [IDX_W-1:0]     win_idx;
    match_evt_t           evt;

    i2c_slot_compare #(.NUM_SLOTS(NUM_SLOTS)) u_cmp (
        .rx_byte   (rx_byte),
        .slot_addr (slot_addr),
        .slot_mask (slot_mask),
        .addr_hit  (addr_hit),
        .gc_enable (gc_enable)
    );

    // A zero byte is judged only as a General Call
    assign is_gc   = (rx_byte == '0);
    assign sel_req = is_gc ? gc_enable : addr_hit;

    i2c_prio_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
        .req   (sel_req),
        .found (any_hit),
        .idx   (win_idx)
    );

    // Armed from a START until the next completed byte
    always_ff @(posedge clk) begin
        if (rst)             armed <= 1'b0;
        else if (start_seen) armed <= 1'b1;
        else if (byte_valid) armed <= 1'b0;
    end

    assign fire     = byte_valid && armed && any_hit;
    assign evt.gc   = is_gc;
    assign evt.addr = rx_byte;

    i2c_match_event #(.IDX_W(IDX_W)) u_evt (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .evt         (evt),
        .idx         (win_idx),
        .irq_clear   (irq_clear),
        .match_pulse (match_pulse),
        .match_slot  (match_slot),
        .gc_hit      (gc_hit),
        .rw_bit      (rw_bit),
        .rx_addr     (rx_addr),
        .irq         (irq)
    );
endmodule

// File: rtl/i2c_addr_matcher_chk.sv
module i2c_addr_matcher_chk (
    input logic       clk,
    input logic       rst,
    input logic       byte_valid,
    input logic [7:0] rx_byte,
    input logic       irq_clear,
    input logic       match_pulse,
    input logic       gc_hit,
    input logic       rw_bit,
    input logic [7:0] rx_addr,
    input logic       irq
);
    // R7: a pulse only follows a byte strobe
    a_r7_pulse_after_strobe: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> $past(byte_valid));

    // R8: interrupt rises only with a match
    a_r8_irq_rise_on_match: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> match_pulse);

    // R8: interrupt holds without a clear
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clear) |=> irq);

    // R5: general call flag only with a match
    a_r5_gc_with_pulse: assert property (@(posedge clk) disable iff (rst)
        gc_hit |-> match_pulse);

    // R9: latched address is the strobed byte
    a_r9_latch_value: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> (rx_addr == $past(rx_byte)));

    // R4: R/W output follows received bit 0
    a_r4_rw_value: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> (rw_bit == $past(rx_byte[0])));

    // R9: latched address holds without a match
    a_r9_latch_holds: assert property (@(posedge clk) disable iff (rst)
        !match_pulse |-> $stable(rx_addr));
endmodule

bind i2c_addr_matcher i2c_addr_matcher_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .byte_valid  (byte_valid),
    .rx_byte     (rx_byte),
    .irq_clear   (irq_clear),
    .match_pulse (match_pulse),
    .gc_hit      (gc_hit),
    .rw_bit      (rw_bit),
    .rx_addr     (rx_addr),
    .irq         (irq)
);

// File: tb/i2c_addr_matcher_bench.sv
`timescale 1ns/1ps
module i2c_addr_matcher_bench;
    logic        clk = 1'b0;
    logic        rst, start_seen, byte_valid, irq_clear;
    logic [7:0]  rx_byte;
    logic [31:0] slot_addr;
    logic [27:0] slot_mask;
    logic        match_pulse, gc_hit, rw_bit, irq;
    logic [1:0]  match_slot;
    logic [7:0]  rx_addr;
    int          errors = 0;
    int          checks = 0;

    always #2 clk = ~clk;

    i2c_addr_matcher u_i2c_addr_matcher (
        .clk(clk), .rst(rst), .start_seen(start_seen), .byte_valid(byte_valid),
        .rx_byte(rx_byte), .slot_addr(slot_addr), .slot_mask(slot_mask),
        .irq_clear(irq_clear), .match_pulse(match_pulse), .match_slot(match_slot),
        .gc_hit(gc_hit), .rw_bit(rw_bit), .rx_addr(rx_addr), .irq(irq)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_slot(int s, logic [7:0] a, logic [6:0] m);
        slot_addr[s*8 +: 8] = a;
        slot_mask[s*7 +: 7] = m;
    endtask

    task automatic do_start();
        @(negedge clk); start_seen = 1'b1;
        @(negedge clk); start_seen = 1'b0;
    endtask

    // Drive a byte; on return, the cycle after the sampling edge
    task automatic send_byte(logic [7:0] b, logic clr = 1'b0);
        @(negedge clk); rx_byte = b; byte_valid = 1'b1; irq_clear = clr;
        @(negedge clk); byte_valid = 1'b0; irq_clear = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clear = 1'b1;
        @(negedge clk); irq_clear = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pulse", {7'd0, match_pulse}, 8'd0);
        chk("R1 irq",   {7'd0, irq}, 8'd0);
        chk("R1 gc",    {7'd0, gc_hit}, 8'd0);
        chk("R1 rw",    {7'd0, rw_bit}, 8'd0);
        chk("R1 slot",  {6'd0, match_slot}, 8'd0);
        chk("R1 addr",  rx_addr, 8'd0);
    endtask

    task automatic t_exact();
        do_start(); send_byte(8'hA1);
        chk("R7 pulse", {7'd0, match_pulse}, 8'd1);
        chk("R2 slot",  {6'd0, match_slot}, 8'd0);
        chk("R4 rw",    {7'd0, rw_bit}, 8'd1);
        chk("R9 addr",  rx_addr, 8'hA1);
        chk("R8 irq",   {7'd0, irq}, 8'd1);
        @(negedge clk);
        chk("R7 one cycle", {7'd0, match_pulse}, 8'd0);
        chk("R8 held", {7'd0, irq}, 8'd1);
        clear_irq();
        chk("R8 cleared", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_mask();
        do_start(); send_byte(8'h6A);
        chk("R2 mask pulse", {7'd0, match_pulse}, 8'd1);
        chk("R2 mask slot",  {6'd0, match_slot}, 8'd1);
        chk("R4 rw0", {7'd0, rw_bit}, 8'd0);
        clear_irq();
    endtask

    task automatic t_prio();
        do_start(); send_byte(8'h60);
        chk("R3 lowest slot", {6'd0, match_slot}, 8'd1);
        set_slot(1, 8'h10, 7'h00);
        do_start(); send_byte(8'h61);
        chk("R3 next slot", {6'd0, match_slot}, 8'd3);
        chk("R4 rw1", {7'd0, rw_bit}, 8'd1);
        clear_irq();
    endtask

    task automatic t_gc();
        do_start(); send_byte(8'h00);
        chk("R5 gc pulse", {7'd0, match_pulse}, 8'd1);
        chk("R5 gc flag",  {7'd0, gc_hit}, 8'd1);
        chk("R5 gc slot",  {6'd0, match_slot}, 8'd2);
        clear_irq();
        set_slot(2, 8'h42, 7'h00);
        do_start(); send_byte(8'h00);
        chk("R5 gc disabled", {7'd0, match_pulse}, 8'd0);
        chk("R5 gc no irq", {7'd0, irq}, 8'd0);
        chk("R5 gc addr kept", rx_addr, 8'h00);
    endtask

    task automatic t_later_bytes();
        do_start(); send_byte(8'hA0);
        chk("R6 first byte", {7'd0, match_pulse}, 8'd1);
        clear_irq();
        send_byte(8'h60);
        chk("R6 data pulse", {7'd0, match_pulse}, 8'd0);
        chk("R6 data irq", {7'd0, irq}, 8'd0);
        chk("R6 data addr", rx_addr, 8'hA0);
    endtask

    task automatic t_nomatch_restart();
        do_start(); send_byte(8'h22);
        chk("R10 no pulse", {7'd0, match_pulse}, 8'd0);
        chk("R10 no irq", {7'd0, irq}, 8'd0);
        chk("R10 addr kept", rx_addr, 8'hA0);
        do_start(); send_byte(8'h61);
        chk("R6 restart", {7'd0, match_pulse}, 8'd1);
        chk("R9 reload", rx_addr, 8'h61);
    endtask

    task automatic t_set_wins();
        do_start(); send_byte(8'hA0, 1'b1);
        chk("R8 set over clear", {7'd0, irq}, 8'd1);
        clear_irq();
        chk("R8 clear", {7'd0, irq}, 8'd0);
    endtask

    initial begin
        rst = 1'b1; start_seen = 1'b0; byte_valid = 1'b0; irq_clear = 1'b0;
        rx_byte = 8'h00; slot_addr = '0; slot_mask = '0;
        set_slot(0, 8'hA0, 7'h00);
        set_slot(1, 8'h60, 7'h07);
        set_slot(2, 8'h43, 7'h00);
        set_slot(3, 8'h60, 7'h00);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_exact();
        t_mask();
        t_prio();
        t_gc();
        t_later_bytes();
        t_nomatch_restart();
        t_set_wins();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule